// File: doc/BRIEF.md
# Two-Channel Amplifier Gain Loader

This block is a serial-peripheral master that programs a two-channel preamplifier. A host presents two 4-bit gain codes, one per channel, on a valid/ready request port. When the request is taken, the block joins the codes into one 8-bit command, pulls the active-low select down and shifts the command out most significant bit first. The channel B code goes out before the channel A code. The serial clock is a divided copy of the system clock and idles low. The amplifier changes its output on falling serial-clock edges and the block samples it on rising edges.

The amplifier sends its previous configuration back while the new command goes in, so every transfer is also a readback. The 8 echoed bits are put together in the same B-then-A order. When the select is released they are shown as two separate nibbles, with a one-cycle done pulse.

Request port rules: the host raises `req_valid` with the gain codes and holds them until it sees `req_ready` at a clock edge. `req_ready` is low for the whole frame, so the host is back-pressured and no request can be taken mid-frame. The readback side has no back-pressure. Its nibbles stay valid from the done pulse until the next done pulse.

Top module: `amp_gain_spi`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `mosi` is 0, `busy` and `done` are 0, `req_ready` is 1, and `old_a`/`old_b` are 0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. At that same edge `cs_n` goes to 0 and `busy` goes to 1.
- R3: While `cs_n` is 0, `mosi` carries the 8-bit command `{gain_b, gain_a}`. The bits go out in the order gain_b[3], gain_b[2], gain_b[1], gain_b[0], gain_a[3], gain_a[2], gain_a[1], gain_a[0], and each bit is held for 2*HALF_DIV clocks. `mosi` never changes while `sck` is high.
- R4: Every `sck` high phase and every low phase inside a frame lasts exactly HALF_DIV system clocks. A frame has exactly 8 rising edges, and `sck` is 0 whenever `cs_n` is 1.
- R5: The first rising edge of `sck` comes HALF_DIV clocks after the edge where the request is taken.
- R6: `cs_n` returns to 1 and `busy` to 0 exactly 17*HALF_DIV clocks after the edge where the request is taken. This leaves one full low half-period after the last falling edge.
- R7: `miso` is sampled on each rising edge of `sck`. The first 4 bits sampled become `old_b` (MSB first) and the last 4 become `old_a`. Both are updated at the edge where `cs_n` is released. `done` is high for exactly that one cycle.
- R8: While `busy` is 1, `req_ready` is 0 and `req_valid` has no effect. The frame in flight keeps its command and no second frame starts.
- R9: `mosi` is 0 after the last command bit and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Gain request present |
| req_ready | output | 1 | Request can be taken (idle) |
| gain_a | input | 4 | New gain code, channel A |
| gain_b | input | 4 | New gain code, channel B |
| busy | output | 1 | Frame in progress |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low amplifier select |
| mosi | output | 1 | Serial command data |
| miso | input | 1 | Serial echo from amplifier |
| done | output | 1 | One-cycle pulse at frame end |
| old_a | output | 4 | Echoed previous channel A code |
| old_b | output | 4 | Echoed previous channel B code |

## Verification
Every output is a register, so all timing is counted from the edge that takes the request, call it edge 0. After edge c, `sck` is high when floor(c/HALF_DIV) is odd and below 16. `mosi` carries command bit 7-floor(c/(2*HALF_DIV)). `cs_n`, `busy`, `done` and the readback nibbles change at edge 17*HALF_DIV. The bench drives inputs and samples on the falling clock edge. For each of the 17*HALF_DIV+1 cycles it compares every output with these formulas, and it checks the captured command and the readback once the frame ends. All 256 gain pairs are swept. A bench slave model echoes each previous command, so the expected readback is the pair sent before.

// File: rtl/amp_spi_pkg.sv
package amp_spi_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } xfer_state_e;

  // half-period index at which the frame is released
  function automatic int release_phase(input int bits);
    return 2 * bits;
  endfunction
endpackage

// File: rtl/amp_spi_tick.sv
module amp_spi_tick #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (!run || cnt == CNT_MAX) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == CNT_MAX);

      assert_tick_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
    end
  endgenerate
endmodule

// File: rtl/amp_spi_seq.sv
module amp_spi_seq
  import amp_spi_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic sck,
  output logic cs_n,
  output logic done,
  output logic load,
  output logic shift_en,
  output logic sample_en,
  output logic finish
);
  localparam int LAST_I = release_phase(BITS);
  localparam int IW = $clog2(LAST_I + 1);
  localparam logic [IW-1:0] LAST = IW'(LAST_I);

  xfer_state_e state;
  logic [IW-1:0] phase;

  assign busy      = (state == ST_XFER);
  assign load      = start && !busy;
  assign finish    = busy && tick && (phase == LAST);
  assign sample_en = busy && tick && !phase[0] && (phase < LAST);
  assign shift_en  = busy && tick && phase[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= '0;
      sck   <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        state <= ST_XFER;
        phase <= '0;
        sck   <= 1'b0;
        cs_n  <= 1'b0;
      end else if (finish) begin
        state <= ST_IDLE;
        phase <= '0;
        sck   <= 1'b0;
        cs_n  <= 1'b1;
        done  <= 1'b1;
      end else if (busy && tick) begin
        phase <= phase + 1'b1;
        sck   <= ~phase[0];
      end
    end
  end

  assert_phase_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $fell(cs_n));
endmodule

// File: rtl/amp_spi_shreg.sv
module amp_spi_shreg #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            shift_en,
  input  logic            sample_en,
  input  logic            sdi,
  output logic            sdo,
  output logic [BITS-1:0] rx
);
  logic [BITS-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0;
      rx <= '0;
    end else begin
      if (load) tx <= load_data;
      else if (shift_en) tx <= {tx[BITS-2:0], 1'b0};
      if (sample_en) rx <= {rx[BITS-2:0], sdi};
    end
  end

  assign sdo = tx[BITS-1];
endmodule

// File: rtl/amp_gain_spi.sv
module amp_gain_spi #(
  parameter int NIB_W    = 4,
  parameter int HALF_DIV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NIB_W-1:0] gain_a,
  input  logic [NIB_W-1:0] gain_b,
  output logic             busy,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             done,
  output logic [NIB_W-1:0] old_a,
  output logic [NIB_W-1:0] old_b
);
  localparam int BITS = 2 * NIB_W;

  logic tick, load, shift_en, sample_en, finish;
  logic [BITS-1:0] rx_word;
  logic [BITS-1:0] result;

  assign req_ready = !busy;

  amp_spi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  amp_spi_seq #(.BITS(BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(req_valid), .tick(tick),
    .busy(busy), .sck(sck), .cs_n(cs_n), .done(done), .load(load),
    .shift_en(shift_en), .sample_en(sample_en), .finish(finish)
  );

  amp_spi_shreg #(.BITS(BITS)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data({gain_b, gain_a}),
    .shift_en(shift_en), .sample_en(sample_en), .sdi(miso),
    .sdo(mosi), .rx(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else if (finish) result <= rx_word;
  end

  assign old_b = result[BITS-1:NIB_W];
  assign old_a = result[NIB_W-1:0];

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_cs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(req_valid && req_ready));
  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));
  assert_mosi_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !mosi);
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$fell(cs_n));
endmodule

// File: tb/sim_amp_gain_spi.sv
`timescale 1ns/1ps
module sim_amp_gain_spi;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] gain_a = '0, gain_b = '0;
  logic req_ready, busy, sck, cs_n, mosi, done;
  logic miso = 1'b0;
  logic [3:0] old_a, old_b;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  amp_gain_spi #(.NIB_W(4), .HALF_DIV(H)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .gain_a(gain_a), .gain_b(gain_b), .busy(busy), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .done(done), .old_a(old_a), .old_b(old_b)
  );

  // slave model: echoes its stored configuration, stores what it receives
  logic [7:0] slave_cfg = 8'hA5;
  logic [7:0] slave_out = '0;
  logic [7:0] slave_rx = '0;
  int rises = 0;
  bit armed = 0;

  always @(negedge cs_n) begin
    armed <= 1;
    rises <= 0;
    slave_out <= slave_cfg;
    miso <= slave_cfg[7];
  end
  always @(negedge sck) if (!cs_n) begin
    slave_out <= {slave_out[6:0], 1'b0};
    miso <= slave_out[6];
  end
  always @(posedge sck) if (!cs_n) begin
    slave_rx <= {slave_rx[6:0], mosi};
    rises <= rises + 1;
  end
  always @(posedge cs_n) if (armed) slave_cfg <= slave_rx;

  // mosi must not move while sck stays high (R3)
  logic prev_sck = 0, prev_mosi = 0;
  int mosi_viol = 0;
  always @(negedge clk) begin
    if (rst_n && sck && prev_sck && mosi != prev_mosi) mosi_viol++;
    prev_sck <= sck;
    prev_mosi <= mosi;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [7:0] exp_prev = 8'hA5;

  task automatic xfer(input logic [3:0] a, input logic [3:0] b, input bit try_ignore);
    logic [7:0] cmd;
    int bad_sck, bad_cs, bad_mosi, bad_done, bad_busy, bad_ready;
    cmd = {b, a};
    bad_sck = 0; bad_cs = 0; bad_mosi = 0; bad_done = 0; bad_busy = 0; bad_ready = 0;
    @(negedge clk);
    gain_a = a; gain_b = b; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c <= 17 * H; c++) begin
      int idx;
      logic e_sck, e_mosi;
      idx = c / H;
      e_sck = (idx % 2 == 1) && (idx < 16);
      e_mosi = (idx < 16) ? cmd[7 - idx / 2] : 1'b0;
      if (sck !== e_sck) bad_sck++;
      if (cs_n !== (c >= 17 * H)) bad_cs++;
      if (busy !== (c < 17 * H)) bad_busy++;
      if (done !== (c == 17 * H)) bad_done++;
      if (mosi !== e_mosi) bad_mosi++;
      if (try_ignore && c >= 3 * H && c < 17 * H - 1) begin
        // R8: foreign request held during the frame
        req_valid = 1'b1; gain_a = ~a; gain_b = ~b;
        if (req_ready !== 1'b0) bad_ready++;
      end else if (try_ignore && c == 17 * H - 1) begin
        req_valid = 1'b0; gain_a = a; gain_b = b;
      end
      if (c < 17 * H) @(negedge clk);
    end
    chk(bad_sck == 0, "R4 R5 sck waveform", bad_sck, 0);
    chk(bad_cs == 0, "R6 cs_n framing", bad_cs, 0);
    chk(bad_busy == 0, "R6 busy window", bad_busy, 0);
    chk(bad_done == 0, "R7 done timing", bad_done, 0);
    chk(bad_mosi == 0, "R3 R9 mosi bits", bad_mosi, 0);
    chk({old_b, old_a} == exp_prev, "R7 readback", {old_b, old_a}, exp_prev);
    @(negedge clk);
    chk(slave_rx == cmd, "R3 command received", slave_rx, cmd);
    chk(rises == 8, "R4 rising edges", rises, 8);
    if (try_ignore) begin
      chk(bad_ready == 0, "R8 ready low while busy", bad_ready, 0);
      for (int k = 0; k < 3; k++) begin
        chk(cs_n == 1'b1 && done == 1'b0, "R8 no second frame", cs_n, 1);
        @(negedge clk);
      end
    end
    chk({old_b, old_a} == exp_prev, "R7 readback held", {old_b, old_a}, exp_prev);
    exp_prev = cmd;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sck == 0 && mosi == 0, "R1 reset pins", {cs_n, sck, mosi}, 4);
    chk(busy == 0 && done == 0 && req_ready == 1, "R1 reset status",
        {busy, done, req_ready}, 1);
    chk(old_a == 0 && old_b == 0, "R1 reset readback", {old_b, old_a}, 0);
    rst_n = 1'b1;
    // gain codes 0110 and 0111 on the two channels
    xfer(4'b0110, 4'b0111, 1'b0);
    xfer(4'b0111, 4'b0110, 1'b1);
    for (int b = 0; b < 16; b++)
      for (int a = 0; a < 16; a++)
        xfer(4'(a), 4'(b), (a == b) && (a % 5 == 0));
    chk(mosi_viol == 0, "R3 mosi stable while sck high", mosi_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule